// File: doc/BRIEF.md
# Manchester Word Encoder with Sync Character

This block turns one 16-bit word into a framed Manchester II line signal. Every frame is 20 bit times long. It opens with a sync character three bit times long, carries 16 data bits with the most significant bit first, and closes with one odd parity bit. The block runs from a clock at twice the bit rate, so one clock cycle is one half-bit on the line.

The block pulls its data from an external serial source, such as a shift register. It gives that source a bit-rate shift clock and a send-data window. The block samples one data bit on each rising shift-clock edge inside the window. The sync type is chosen per frame. A command sync is positive for 1.5 bit times and then negative for 1.5 bit times. A data sync is the reverse.

The line is driven through two active-low outputs, one for the positive sense and one for the negative sense. When both are high, the line is undriven. If enable is held high, frames follow one another with no gap. An inhibit input silences the line without disturbing the encoder. An abort input returns the block to its idle state at the next clock edge.

Top module: `mword_encoder`

## Requirements
- R1: `sclk_o` toggles on every `clk_i` edge when `abort_i` is low. It is low after reset and low after an abort edge.
- R2: A frame starts when `en_i` is sampled high at a falling shift-clock edge while idle. This is a clock edge at which `sclk_o` was high before the edge. The line becomes active after the next clock edge and stays active for 40 consecutive clock cycles.
- R3: `sync_sel_i` is sampled at the edge that starts the frame. When it is 1, the first three half-bits are positive and the next three are negative. When it is 0, the order is reversed. On the outputs, positive means `pos_n_o`=0 and `neg_n_o`=1; negative means `pos_n_o`=1 and `neg_n_o`=0.
- R4: `send_o` is high for exactly 32 clock cycles (16 shift-clock periods) per frame. It rises while `sclk_o` is low. `data_i` is sampled at each of the 16 clock edges where `sclk_o` rises inside that window. The first bit sampled is data bit 15.
- R5: Each data bit occupies two half-bits, in half-bits 6 to 37 of the frame. A 1 is sent as positive then negative. A 0 is sent as negative then positive.
- R6: Half-bits 38 and 39 carry one parity bit, encoded like a data bit. The parity bit is chosen so that the 16 data bits plus the parity bit contain an odd number of ones.
- R7: If `en_i` is high at the falling shift-clock edge that starts half-bit 39, the next frame follows with no idle cycle. If it is low there, the line goes idle after half-bit 39.
- R8: While `inhibit_ni` is low, both `pos_n_o` and `neg_n_o` are high. The shift clock, the send window, data sampling and frame sequencing carry on unchanged.
- R9: `abort_i` high at a clock edge ends any frame or pending start. After that edge the line is idle, `send_o` is low and `sclk_o` is low. A later enable starts a correct new frame.
- R10: With no frame in progress, both `pos_n_o` and `neg_n_o` are high. The two outputs are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| abort_i | input | 1 | Synchronous abort of the current frame |
| en_i | input | 1 | Encoder enable; starts a frame, or continues with the next one |
| sync_sel_i | input | 1 | Sync type: 1 for command, 0 for data |
| data_i | input | 1 | Serial NRZ data from the external source |
| inhibit_ni | input | 1 | Output inhibit, active low |
| sclk_o | output | 1 | Bit-rate shift clock |
| send_o | output | 1 | Send-data window for the external source |
| pos_n_o | output | 1 | Positive line sense, active low |
| neg_n_o | output | 1 | Negative line sense, active low |

## Verification
The scoreboard checks every half-bit of each frame against a model built from the requirements.

The data words are chosen to expose three kinds of faults:
- All zeros and all ones show a parity bit with the wrong sense.
- A single set bit at either end shows a reversed bit order, or a sampling edge that is off by one.
- An alternating pattern shows a fault in the Manchester transitions.

A back-to-back pair switches the sync type between its two frames. This catches a design that inserts an idle half-bit at the seam, or that reuses the previous frame's sync select. An inhibited frame must leave the line silent and still consume a full word, so that the frame after it lines up. An abort in the middle of a frame must leave the block ready for a clean frame, rather than carrying on from a stale count.

// File: rtl/mwe_pkg.sv
package mwe_pkg;
  typedef enum logic [1:0] {
    LINE_OFF = 2'd0,
    LINE_POS = 2'd1,
    LINE_NEG = 2'd2
  } line_e;
endpackage

// File: rtl/mwe_sequencer.sv
module mwe_sequencer #(
  parameter int FRAME_HALVES = 40,
  parameter int SEND_FIRST   = 5,
  parameter int SEND_LAST    = 36,
  parameter int HW           = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          abort_i,
  input  logic          en_i,
  output logic          sclk_o,
  output logic          start_o,
  output logic          next_active_o,
  output logic [HW-1:0] next_half_o,
  output logic          send_o
);
  localparam logic [HW-1:0] LAST_H = HW'(FRAME_HALVES - 1);
  localparam logic [HW-1:0] CONT_H = HW'(FRAME_HALVES - 2);
  localparam logic [HW-1:0] SND_LO = HW'(SEND_FIRST);
  localparam logic [HW-1:0] SND_HI = HW'(SEND_LAST);

  logic          phase_q, active_q, pend_q, send_q;
  logic [HW-1:0] half_q;
  logic          rise, fall;

  // phase_q low before an edge means the edge raises sclk
  assign rise = ~phase_q;
  assign fall = phase_q;

  assign start_o       = rise & pend_q;
  assign next_active_o = start_o | (active_q & (half_q != LAST_H));
  assign next_half_o   = start_o ? '0 : half_q + 1'b1;
  assign sclk_o        = phase_q;
  assign send_o        = send_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= 1'b0;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      half_q   <= '0;
      send_q   <= 1'b0;
    end else if (abort_i) begin
      phase_q  <= 1'b0;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      half_q   <= '0;
      send_q   <= 1'b0;
    end else begin
      phase_q  <= ~phase_q;
      active_q <= next_active_o;
      half_q   <= next_active_o ? next_half_o : '0;
      send_q   <= next_active_o && (next_half_o >= SND_LO) && (next_half_o <= SND_HI);
      if (start_o)
        pend_q <= 1'b0;
      else if (fall && en_i && (!active_q || half_q == CONT_H))
        pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mwe_symbol.sv
module mwe_symbol
  import mwe_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_HALVES = 3,
  parameter int HW          = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          abort_i,
  input  logic          start_i,
  input  logic          sync_sel_i,
  input  logic          data_i,
  input  logic          next_active_i,
  input  logic [HW-1:0] next_half_i,
  output line_e         line_o
);
  localparam logic [HW-1:0] SYNC_MID = HW'(SYNC_HALVES);
  localparam logic [HW-1:0] DATA_LO  = HW'(2 * SYNC_HALVES);
  localparam logic [HW-1:0] PAR_LO   = HW'(2 * SYNC_HALVES + 2 * DATA_W);

  line_e line_q;
  logic  cmd_q, bit_q, par_q;
  logic  cmd, second, bit_val, level_pos, take;

  assign second = next_half_i[0];
  assign cmd    = start_i ? sync_sel_i : cmd_q;
  assign take   = next_active_i && !second &&
                  (next_half_i >= DATA_LO) && (next_half_i < PAR_LO);

  always_comb begin
    bit_val   = 1'b0;
    level_pos = 1'b0;
    if (next_half_i < DATA_LO) begin
      level_pos = cmd ? (next_half_i < SYNC_MID) : (next_half_i >= SYNC_MID);
    end else begin
      if (next_half_i < PAR_LO) bit_val = second ? bit_q : data_i;
      else                      bit_val = ~par_q;  // odd parity
      level_pos = second ? ~bit_val : bit_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= LINE_OFF;
      cmd_q  <= 1'b0;
      bit_q  <= 1'b0;
      par_q  <= 1'b0;
    end else if (abort_i) begin
      line_q <= LINE_OFF;
      cmd_q  <= 1'b0;
      bit_q  <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      line_q <= next_active_i ? (level_pos ? LINE_POS : LINE_NEG) : LINE_OFF;
      if (start_i) begin
        cmd_q <= sync_sel_i;
        par_q <= 1'b0;
      end
      if (take) begin
        bit_q <= data_i;
        par_q <= par_q ^ data_i;
      end
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/mwe_outdrv.sv
module mwe_outdrv
  import mwe_pkg::*;
(
  input  line_e line_i,
  input  logic  inhibit_ni,
  output logic  pos_n_o,
  output logic  neg_n_o
);
  assign pos_n_o = ~((line_i == LINE_POS) & inhibit_ni);
  assign neg_n_o = ~((line_i == LINE_NEG) & inhibit_ni);
endmodule

// File: rtl/mword_encoder.sv
module mword_encoder
  import mwe_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_HALVES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_i,
  input  logic en_i,
  input  logic sync_sel_i,
  input  logic data_i,
  input  logic inhibit_ni,
  output logic sclk_o,
  output logic send_o,
  output logic pos_n_o,
  output logic neg_n_o
);
  localparam int FRAME_HALVES = 2 * SYNC_HALVES + 2 * DATA_W + 2;
  localparam int HW           = $clog2(FRAME_HALVES);
  localparam int SEND_FIRST   = 2 * SYNC_HALVES - 1;
  localparam int SEND_LAST    = 2 * SYNC_HALVES + 2 * DATA_W - 2;

  logic          start, next_active;
  logic [HW-1:0] next_half;
  line_e         line;

  mwe_sequencer #(
    .FRAME_HALVES(FRAME_HALVES),
    .SEND_FIRST  (SEND_FIRST),
    .SEND_LAST   (SEND_LAST),
    .HW          (HW)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .abort_i      (abort_i),
    .en_i         (en_i),
    .sclk_o       (sclk_o),
    .start_o      (start),
    .next_active_o(next_active),
    .next_half_o  (next_half),
    .send_o       (send_o)
  );

  mwe_symbol #(
    .DATA_W     (DATA_W),
    .SYNC_HALVES(SYNC_HALVES),
    .HW         (HW)
  ) u_sym (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .abort_i      (abort_i),
    .start_i      (start),
    .sync_sel_i   (sync_sel_i),
    .data_i       (data_i),
    .next_active_i(next_active),
    .next_half_i  (next_half),
    .line_o       (line)
  );

  mwe_outdrv u_drv (
    .line_i    (line),
    .inhibit_ni(inhibit_ni),
    .pos_n_o   (pos_n_o),
    .neg_n_o   (neg_n_o)
  );
endmodule

// File: rtl/mwe_checker.sv
module mwe_checker #(
  parameter int DATA_W = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic abort_i,
  input logic inhibit_ni,
  input logic sclk_o,
  input logic send_o,
  input logic pos_n_o,
  input logic neg_n_o
);
  localparam int CW = $clog2(2 * DATA_W + 2);
  localparam logic [CW-1:0] WIN = CW'(2 * DATA_W);

  logic [CW-1:0] send_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      send_cnt <= '0;
    else if (abort_i) send_cnt <= '0;
    else              send_cnt <= send_o ? send_cnt + 1'b1 : '0;
  end

  assert_sclk_toggle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_i |=> (sclk_o != $past(sclk_o)));

  assert_line_on_in_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_o && inhibit_ni) |-> !(pos_n_o && neg_n_o));

  assert_send_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(send_o) |-> !sclk_o);

  assert_send_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(send_o) && !$past(abort_i)) |-> (send_cnt == WIN));

  assert_inhibit_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inhibit_ni |-> (pos_n_o && neg_n_o));

  assert_abort_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!sclk_o && !send_o && pos_n_o && neg_n_o));

  assert_never_both_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!pos_n_o && !neg_n_o));
endmodule

bind mword_encoder mwe_checker #(.DATA_W(DATA_W)) u_mwe_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .abort_i   (abort_i),
  .inhibit_ni(inhibit_ni),
  .sclk_o    (sclk_o),
  .send_o    (send_o),
  .pos_n_o   (pos_n_o),
  .neg_n_o   (neg_n_o)
);

// File: tb/mword_encoder_test.sv
module mword_encoder_test;
  logic clk = 1'b0, rst_n = 1'b0, abort = 1'b0, en = 1'b0;
  logic ssel = 1'b0, din = 1'b0, inh_n = 1'b1;
  logic sclk, send, pn, nn;

  always #5 clk = ~clk;

  mword_encoder uut (
    .clk_i(clk), .rst_ni(rst_n), .abort_i(abort), .en_i(en),
    .sync_sel_i(ssel), .data_i(din), .inhibit_ni(inh_n),
    .sclk_o(sclk), .send_o(send), .pos_n_o(pn), .neg_n_o(nn)
  );

  typedef struct {
    logic [1:0] lvl;
    string      req;
    int         idx;
  } exp_t;

  exp_t        expq[$];
  logic [15:0] wq[$];
  logic [15:0] cur_w = 16'h0;
  int bc = 0, run = 0, max_run = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // driver side: expected half-bits {pos_n,neg_n}, positive = 2'b01
  task automatic push_frame(input logic [15:0] w, input bit cmd);
    for (int k = 0; k < 40; k++) begin
      bit pos;
      string r;
      if (k < 6) begin
        pos = cmd ? (k < 3) : (k >= 3);
        r = "R3";
      end else if (k < 38) begin
        pos = w[15 - (k - 6) / 2] ^ ((k % 2) == 1);
        r = "R5";
      end else begin
        pos = (~^w) ^ (k == 39);
        r = "R6";
      end
      expq.push_back('{pos ? 2'b01 : 2'b10, r, k});
    end
    wq.push_back(w);
  endtask

  // external serial source
  always @(negedge clk) begin
    if (send && !sclk) begin
      if (bc == 0) cur_w = (wq.size() > 0) ? wq.pop_front() : 16'h0;
      din = cur_w[15 - bc];
      bc = (bc == 15) ? 0 : bc + 1;
    end
  end

  // monitor
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n) begin
      if ({pn, nn} != 2'b11) begin
        run++;
        if (run > max_run) max_run = run;
        if (expq.size() == 0) check(1'b0, "R10", "unexpected active half", {pn, nn}, 3);
        else begin
          e = expq.pop_front();
          check({pn, nn} == e.lvl, e.req, $sformatf("half %0d", e.idx), {pn, nn}, e.lvl);
        end
      end else run = 0;
    end
  end

  task automatic run_single(input logic [15:0] w, input bit cmd, input string req);
    max_run = 0;
    push_frame(w, cmd);
    ssel = cmd;
    en = 1'b1;
    do @(negedge clk); while ({pn, nn} == 2'b11);
    en = 1'b0;
    repeat (45) @(negedge clk);
    check(max_run == 40, req, $sformatf("frame length word %h", w), max_run, 40);
    check(expq.size() == 0, req, "leftover halves", expq.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pn && nn, "R10", "reset line idle", {pn, nn}, 3);
    check(!send, "R4", "reset send low", send, 0);
    check(!sclk, "R1", "reset sclk low", sclk, 0);
    rst_n = 1'b1;

    // R1: toggles every cycle
    for (int i = 0; i < 8; i++) begin
      logic prev;
      prev = sclk;
      @(negedge clk);
      check(sclk != prev, "R1", "sclk toggle", sclk, !prev);
    end

    // R2: start latency from a falling shift-clock edge
    max_run = 0;
    push_frame(16'hA5C3, 1'b1);
    ssel = 1'b1;
    while (!sclk) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check(pn && nn, "R2", "idle after fall edge", {pn, nn}, 3);
    @(negedge clk);
    check({pn, nn} != 2'b11, "R2", "active after next edge", {pn, nn}, 1);
    en = 1'b0;
    repeat (45) @(negedge clk);
    check(max_run == 40, "R2", "first frame length", max_run, 40);
    repeat (4) @(negedge clk);

    run_single(16'h0000, 1'b0, "R6");
    run_single(16'hFFFF, 1'b1, "R6");
    run_single(16'h0001, 1'b0, "R4");
    run_single(16'h8000, 1'b1, "R4");

    // R7: back-to-back with sync change
    max_run = 0;
    push_frame(16'h1234, 1'b1);
    push_frame(16'h8001, 1'b0);
    ssel = 1'b1;
    en = 1'b1;
    do @(negedge clk); while ({pn, nn} == 2'b11);
    begin
      int c;
      c = 1;
      while (c < 41) begin
        @(negedge clk);
        if ({pn, nn} != 2'b11) c++;
        if (c == 10) ssel = 1'b0;
      end
    end
    en = 1'b0;
    repeat (90) @(negedge clk);
    check(max_run == 80, "R7", "gapless pair length", max_run, 80);
    check(expq.size() == 0, "R7", "pair leftover", expq.size(), 0);

    // R8: inhibited frame still runs
    begin
      int sc, act;
      inh_n = 1'b0;
      wq.push_back(16'h5555);
      en = 1'b1;
      act = 0;
      do begin
        @(negedge clk);
        if ({pn, nn} != 2'b11) act++;
      end while (!send);
      en = 1'b0;
      sc = 1;
      repeat (60) begin
        @(negedge clk);
        if (send) sc++;
        if ({pn, nn} != 2'b11) act++;
      end
      check(sc == 32, "R8", "send window while inhibited", sc, 32);
      check(act == 0, "R8", "line active while inhibited", act, 0);
      check(bc == 0, "R8", "word fully consumed", bc, 0);
      inh_n = 1'b1;
      repeat (4) @(negedge clk);
    end
    run_single(16'h5A5A, 1'b1, "R8");

    // R9: abort mid-frame
    push_frame(16'hC0DE, 1'b1);
    ssel = 1'b1;
    en = 1'b1;
    do @(negedge clk); while ({pn, nn} == 2'b11);
    en = 1'b0;
    repeat (12) @(negedge clk);
    abort = 1'b1;
    @(posedge clk);
    #1;
    expq.delete();
    wq.delete();
    bc = 0;
    @(negedge clk);
    abort = 1'b0;
    check(pn && nn, "R9", "line idle after abort", {pn, nn}, 3);
    check(!send, "R9", "send low after abort", send, 0);
    check(!sclk, "R9", "sclk low after abort", sclk, 0);
    repeat (5) @(negedge clk);
    run_single(16'h3C3C, 1'b0, "R9");

    check(expq.size() == 0, "R10", "scoreboard drained", expq.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule